// File: doc/BRIEF.md
# Scrolling Scan Line Address Generator

During display refresh this block names the row of display memory whose bits go to the segment drivers in each common-electrode line period. A field begins with a line strobe that carries a field-start flag. In that cycle the block samples the start line, the multiplex setting and the row-mirror bit. It then issues one address per line strobe until the field's line count is used up.

Scrolling and flipping are done by address arithmetic alone, so display memory is never rewritten. A non-zero start line shifts the picture by that many rows, and changing it between fields scrolls the display. With mirroring on, the field starts at the far end of the visible window and counts down, which turns the image upside down. All sums wrap modulo the number of memory rows, 80 by default. Each wrap is done with one compare and one adjust, and no divider is used.

Top module: `scan_line_gen`

## Requirements
- R1: While rst_ni is low, line_addr_o is 0 and line_valid_o and field_done_o are 0.
- R2: With mirror_i = 0 sampled, the first line of a field is the start line. A start_line_i value of 80 or more is first reduced by 80.
- R3: With mirror off, each later line of the field is the previous address plus 1, and 79 is followed by 0.
- R4: With mirror_i = 1 sampled, the first line is (start line + mux_cfg_i) mod 80.
- R5: With mirror on, each later line is the previous address minus 1, and 0 is followed by 79.
- R6: start_line_i, mux_cfg_i and mirror_i are sampled only in the cycle where line_stb_i and field_start_i are both 1. Changing them later in the field has no effect until the next field starts.
- R7: A field holds mux_cfg_i + 1 lines, and a mux_cfg_i value above 79 counts as 79. Line strobes after the last line of a field produce no line_valid_o.
- R8: field_done_o is a one-cycle pulse in the cycle after line_valid_o presents the last line of a field.
- R9: field_start_i without line_stb_i is ignored. A field start with a strobe during a running field ends that field at once and begins a new one.
- R10: line_valid_o pulses for one cycle, in the cycle after each accepted strobe, together with the new address. At all other times line_addr_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | 1 | Start of a line period |
| field_start_i | input | 1 | Marks the strobe that begins a field |
| start_line_i | input | 7 | Scroll offset in rows |
| mux_cfg_i | input | 7 | Line count of a field minus one |
| mirror_i | input | 1 | 1 = row mirror (count down) |
| line_addr_o | output | 7 | Memory row for the current line period |
| line_valid_o | output | 1 | New address presented this cycle |
| field_done_o | output | 1 | Field finished |

## Verification
A wrong first-line offset or a wrong sampled mirror bit shows on line_addr_o in the cycle after the field-start strobe. A wrong wrap compare shows only at the line that crosses row 79 or row 0. A line counter that is off by one changes line_valid_o on the strobe just past the field end, and it moves field_done_o by a whole line period. The reference model is compared with every output on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/scan_line_pkg.sv
package scan_line_pkg;
  localparam int unsigned DEF_LINES = 80;
  localparam int unsigned DEF_LINE_W = 7;

  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/scan_mod_adj.sv
// Single compare-and-subtract wrap; input must be below 2*NUM_LINES.
module scan_mod_adj #(
  parameter int unsigned NUM_LINES = 80,
  parameter int unsigned LINE_W    = 7
) (
  input  logic [LINE_W:0]   val_i,
  output logic [LINE_W-1:0] res_o
);
  localparam logic [LINE_W:0] LIM = (LINE_W+1)'(NUM_LINES);
  logic [LINE_W:0] sub;
  always_comb begin
    sub   = val_i - LIM;
    res_o = (val_i >= LIM) ? sub[LINE_W-1:0] : val_i[LINE_W-1:0];
  end
endmodule

// File: rtl/scan_first_line.sv
module scan_first_line #(
  parameter int unsigned NUM_LINES = 80,
  parameter int unsigned LINE_W    = 7,
  parameter int unsigned MUX_W     = 7
) (
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [MUX_W-1:0]  mux_cfg_i,
  input  scan_line_pkg::scan_dir_e dir_i,
  output logic [LINE_W-1:0] first_o,
  output logic [LINE_W-1:0] mux_m1_o
);
  localparam logic [MUX_W-1:0] MUX_MAX = MUX_W'(NUM_LINES - 1);

  logic [LINE_W-1:0] sl_red;
  logic [LINE_W-1:0] sum_red;
  logic [LINE_W:0]   sum;

  scan_mod_adj #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_sl_adj (
    .val_i ({1'b0, start_line_i}),
    .res_o (sl_red)
  );

  always_comb begin
    mux_m1_o = (mux_cfg_i > MUX_MAX) ? LINE_W'(MUX_MAX) : LINE_W'(mux_cfg_i);
    sum      = {1'b0, sl_red} + {1'b0, mux_m1_o};
  end

  scan_mod_adj #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_sum_adj (
    .val_i (sum),
    .res_o (sum_red)
  );

  assign first_o = (dir_i == scan_line_pkg::SCAN_DOWN) ? sum_red : sl_red;
endmodule

// File: rtl/scan_step.sv
module scan_step #(
  parameter int unsigned NUM_LINES = 80,
  parameter int unsigned LINE_W    = 7
) (
  input  logic [LINE_W-1:0] cur_i,
  input  scan_line_pkg::scan_dir_e dir_i,
  output logic [LINE_W-1:0] next_o
);
  localparam logic [LINE_W-1:0] TOP = LINE_W'(NUM_LINES - 1);
  logic [LINE_W-1:0] cand [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    if (d == 0) begin : g_up
      assign cand[d] = (cur_i == TOP) ? '0 : cur_i + 1'b1;
    end else begin : g_dn
      assign cand[d] = (cur_i == '0) ? TOP : cur_i - 1'b1;
    end
  end

  assign next_o = cand[dir_i];
endmodule

// File: rtl/scan_field_ctrl.sv
module scan_field_ctrl #(
  parameter int unsigned LINE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  logic              field_start_i,
  input  logic              mirror_i,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] mux_m1_i,
  input  logic [LINE_W-1:0] next_i,
  output scan_line_pkg::scan_dir_e dir_o,
  output logic [LINE_W-1:0] addr_o,
  output logic              valid_o,
  output logic              done_o
);
  logic [LINE_W-1:0] left_q;
  logic              start_hit;
  logic              step_hit;

  assign start_hit = line_stb_i & field_start_i;
  assign step_hit  = line_stb_i & ~field_start_i & (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= scan_line_pkg::SCAN_UP;
      addr_o  <= '0;
      left_q  <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o  <= valid_o & (left_q == '0);
      valid_o <= start_hit | step_hit;
      if (start_hit) begin
        dir_o  <= scan_line_pkg::scan_dir_e'(mirror_i);
        addr_o <= first_i;
        left_q <= mux_m1_i;
      end else if (step_hit) begin
        addr_o <= next_i;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_line_gen.sv
module scan_line_gen #(
  parameter int unsigned NUM_LINES = scan_line_pkg::DEF_LINES,
  parameter int unsigned LINE_W    = scan_line_pkg::DEF_LINE_W,
  parameter int unsigned MUX_W     = LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  logic              field_start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [MUX_W-1:0]  mux_cfg_i,
  input  logic              mirror_i,
  output logic [LINE_W-1:0] line_addr_o,
  output logic              line_valid_o,
  output logic              field_done_o
);
  scan_line_pkg::scan_dir_e dir_q;
  logic [LINE_W-1:0] first_addr;
  logic [LINE_W-1:0] mux_m1;
  logic [LINE_W-1:0] next_addr;

  scan_first_line #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .MUX_W(MUX_W)) u_first (
    .start_line_i (start_line_i),
    .mux_cfg_i    (mux_cfg_i),
    .dir_i        (scan_line_pkg::scan_dir_e'(mirror_i)),
    .first_o      (first_addr),
    .mux_m1_o     (mux_m1)
  );

  scan_step #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_step (
    .cur_i  (line_addr_o),
    .dir_i  (dir_q),
    .next_o (next_addr)
  );

  scan_field_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_stb_i    (line_stb_i),
    .field_start_i (field_start_i),
    .mirror_i      (mirror_i),
    .first_i       (first_addr),
    .mux_m1_i      (mux_m1),
    .next_i        (next_addr),
    .dir_o         (dir_q),
    .addr_o        (line_addr_o),
    .valid_o       (line_valid_o),
    .done_o        (field_done_o)
  );
endmodule

// File: rtl/scan_line_gen_chk.sv
module scan_line_gen_chk #(
  parameter int unsigned NUM_LINES = 80,
  parameter int unsigned LINE_W    = 7,
  parameter int unsigned MUX_W     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_stb_i,
  input logic              field_start_i,
  input logic [LINE_W-1:0] start_line_i,
  input logic [MUX_W-1:0]  mux_cfg_i,
  input logic              mirror_i,
  input logic [LINE_W-1:0] line_addr_o,
  input logic              line_valid_o,
  input logic              field_done_o
);
  localparam logic [LINE_W-1:0] TOP = LINE_W'(NUM_LINES - 1);

  logic              fld_mir_q;
  logic              first_q;
  logic [LINE_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_mir_q <= 1'b0;
      first_q   <= 1'b0;
      last_q    <= '0;
    end else begin
      first_q <= line_stb_i & field_start_i;
      if (line_stb_i && field_start_i) fld_mir_q <= mirror_i;
      if (line_valid_o) last_q <= line_addr_o;
    end
  end

  p_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_addr_o <= TOP);

  p_valid_from_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> $past(line_stb_i));

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_o |-> $stable(line_addr_o));

  p_done_after_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_done_o |-> $past(line_valid_o));

  p_up_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !first_q && !fld_mir_q) |->
      line_addr_o == ((last_q == TOP) ? '0 : LINE_W'(last_q + 1'b1)));

  p_down_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !first_q && fld_mir_q) |->
      line_addr_o == ((last_q == '0) ? TOP : LINE_W'(last_q - 1'b1)));

  always_comb begin
    if (rst_ni === 1'b0) begin
      a_reset_quiet_r1: assert (line_valid_o == 1'b0 && field_done_o == 1'b0);
    end
  end
endmodule

bind scan_line_gen scan_line_gen_chk #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .MUX_W     (MUX_W)
) u_chk (.*);

// File: tb/scan_line_gen_tb.sv
`timescale 1ns/1ps
module scan_line_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       fs = 1'b0;
  logic [6:0] sl = '0;
  logic [6:0] mux = '0;
  logic       mir = 1'b0;
  logic [6:0] addr;
  logic       valid;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit live = 0;

  always #4 clk = ~clk;

  scan_line_gen u_dut (
    .clk_i (clk), .rst_ni (rst_n), .line_stb_i (stb), .field_start_i (fs),
    .start_line_i (sl), .mux_cfg_i (mux), .mirror_i (mir),
    .line_addr_o (addr), .line_valid_o (valid), .field_done_o (done)
  );

  // behavioural reference
  int    m_addr = 0, m_left = 0, m_mir = 0;
  bit    m_valid = 0, m_done = 0, m_pend = 0;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_left = 0; m_valid = 0; m_done = 0; m_pend = 0; m_tag = "R1";
    end else begin
      m_done  = m_pend;
      m_pend  = 0;
      m_valid = 0;
      if (stb && fs) begin
        int s, n;
        s = int'(sl) % 80;
        n = (int'(mux) > 79) ? 80 : int'(mux) + 1;
        m_mir  = mir;
        m_addr = m_mir ? (s + n - 1) % 80 : s;
        m_left = n - 1;
        m_valid = 1;
        m_tag  = m_mir ? "R4" : "R2";
        if (m_left == 0) m_pend = 1;
      end else if (stb && m_left > 0) begin
        m_addr = m_mir ? (m_addr + 79) % 80 : (m_addr + 1) % 80;
        m_left--;
        m_valid = 1;
        m_tag  = m_mir ? "R5" : "R3";
        if (m_left == 0) m_pend = 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(rst_n ? "R7 R10 R9" : "R1", int'(valid), int'(m_valid), "line_valid_o");
      chk(rst_n ? "R8" : "R1", int'(done), int'(m_done), "field_done_o");
      chk(rst_n ? m_tag : "R1", int'(addr), m_addr, "line_addr_o");
    end
  end

  task automatic pulse(bit with_fs, int gap);
    @(negedge clk);
    stb = 1'b1; fs = with_fs;
    @(negedge clk);
    stb = 1'b0; fs = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic field(int s, int m, bit mr, int lines, int gap);
    sl = 7'(s); mux = 7'(m); mir = mr;
    pulse(1'b1, gap);
    for (int i = 1; i < lines; i++) pulse(1'b0, gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    live = 1;                                  // R1 checked while in reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    field(0, 7, 0, 10, 2);                     // R2 R3 R7: extra strobes ignored
    field(75, 9, 0, 10, 1);                    // R3 wrap 79 -> 0
    field(10, 15, 1, 17, 0);                   // R4 R5 back-to-back strobes
    field(78, 5, 1, 7, 2);                     // R4 R5 wrap 0 -> 79
    field(0, 7, 1, 8, 1);                      // R4 first = 7
    // R6: mid-field changes ignored
    sl = 7'd20; mux = 7'd5; mir = 1'b0;
    pulse(1'b1, 1);
    sl = 7'd60; mux = 7'd1; mir = 1'b1;
    for (int i = 0; i < 7; i++) pulse(1'b0, 1);
    // R9: field_start without strobe ignored
    @(negedge clk); fs = 1'b1; @(negedge clk); fs = 1'b0;
    pulse(1'b0, 2);
    // R9: restart mid-field
    field(30, 10, 0, 4, 1);
    field(5, 3, 1, 5, 1);
    field(100, 120, 0, 82, 1);                 // R2 reduction, R7 clamp to 80 lines
    field(44, 0, 1, 3, 2);                     // R8 single-line field
    field(44, 0, 0, 1, 0);                     // R8 done right after valid
    field(79, 0, 1, 2, 3);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule